// File: doc/BRIEF.md
# Sprite Attribute Table Layout Converter

This block rewrites a table of sprite records held in an on-chip word RAM. The records arrive in one field ordering and leave in another. Each record spans eight 16-bit words. The table begins at a parameterised word address and holds a parameterised number of records. A vertical-sync pulse starts a pass. During the pass the block walks every record in turn. For each record it reads the five meaningful source words into a local buffer, then writes all eight words of the target ordering back to the same record. The two scale words receive the unity value and the trailing word receives zero.

The RAM port is simple and synchronous. Read data appears one cycle after the address, so the sequencer spends two cycles on each read: one to present the address and one to capture the data. A record therefore costs 5×2 read cycles plus 8 write cycles, which is 18 cycles. A busy flag covers the whole pass. A single-cycle done pulse follows the final write.

Top module: `sat_xlate`

## Requirements
- R1: The size word is moved from source word 4 to target word 6, and the target keeps the two-word pairing (code, attribute) and (X, Y): target word 1 holds source word 3 (Y) and target word 3 holds source word 1 (attribute).
- R2: Target words 4 and 5 (X scale, Y scale) are written as 16'h0101 in every record.
- R3: Target word 7 is written as 16'h0000 in every record.
- R4: A pass starts when `vsync_i` is sampled high while the block is idle, and `busy_o` is high in the very next cycle.
- R5: Only the word addresses from BASE_ADDR to BASE_ADDR+8·N_ENTRIES−1 are written. Every word outside that range is left unchanged.
- R6: The conversion is done in place and gives the right result. Target word 0 holds source word 2 (X) and target word 2 holds source word 0 (code). This holds even though each of these slots overwrites a word that another slot still needs.
- R7: A `vsync_i` pulse while `busy_o` is high is ignored. The pass is not restarted or extended, and no new pass follows it.
- R8: `done_o` is high for exactly one cycle. It comes 18·N_ENTRIES+1 cycles after the cycle in which the trigger was sampled, directly after the last write. `busy_o` is low while `done_o` is high.
- R9: While reset is asserted, `busy_o`, `done_o` and `ram_we_o` are low. A write strobe is only ever issued while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | End-of-frame trigger |
| ram_addr_o | output | ADDR_W | RAM word address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, valid one cycle after the address |
| ram_we_o | output | 1 | RAM write enable |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse when a pass ends |

## Verification
The bench drives the trigger at a falling edge. It expects `busy_o` at the next falling edge, one register stage later. It then counts falling edges until `done_o` appears and requires the count to be exactly 18·N_ENTRIES+1. One further falling edge later it requires both `done_o` and `busy_o` to be low. The RAM contents are compared against the expected records only after done, because each word is final once its record's write phase ends. A stray trigger is injected at cycle 100 of one pass; the done timing and data of that pass must match a clean pass, and the block must stay idle afterwards.

// File: rtl/sat_pkg.sv
package sat_pkg;

   localparam int WORDS_PER_ENTRY = 8;
   localparam int SRC_WORDS       = 5;
   localparam int DATA_W          = 16;
   localparam int CYC_PER_ENTRY   = 2 * SRC_WORDS + WORDS_PER_ENTRY;

   localparam logic [DATA_W-1:0] UNITY_SCALE = 16'h0101;
   localparam logic [DATA_W-1:0] PAD_WORD    = 16'h0000;

   // source word slots
   localparam logic [2:0] SRC_CODE = 3'd0;
   localparam logic [2:0] SRC_ATTR = 3'd1;
   localparam logic [2:0] SRC_XPOS = 3'd2;
   localparam logic [2:0] SRC_YPOS = 3'd3;
   localparam logic [2:0] SRC_SIZE = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RADDR,
      ST_RCAP,
      ST_WRITE,
      ST_DONE
   } sat_state_e;

   typedef enum logic [1:0] {
      WK_BUFFER,
      WK_SCALE,
      WK_PAD
   } wr_kind_e;

   typedef struct packed {
      wr_kind_e   kind;
      logic [2:0] src;
   } wr_sel_t;

   function automatic wr_sel_t target_sel(input logic [2:0] slot);
      wr_sel_t s;
      s.kind = WK_BUFFER;
      s.src  = SRC_CODE;
      case (slot)
         3'd0:    s.src  = SRC_XPOS;
         3'd1:    s.src  = SRC_YPOS;
         3'd2:    s.src  = SRC_CODE;
         3'd3:    s.src  = SRC_ATTR;
         3'd4:    s.kind = WK_SCALE;
         3'd5:    s.kind = WK_SCALE;
         3'd6:    s.src  = SRC_SIZE;
         default: s.kind = WK_PAD;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sat_entry_buf.sv
module sat_entry_buf
   import sat_pkg::*;
#(
   parameter int WIDTH = DATA_W,
   parameter int SLOTS = SRC_WORDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [2:0]       cap_idx,
   input  logic [WIDTH-1:0] cap_data,
   input  logic [2:0]       rd_idx,
   output logic [WIDTH-1:0] rd_data
);

   localparam int FLAT_W = SLOTS * WIDTH;

   logic [FLAT_W-1:0] slots_flat;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (cap_en && cap_idx == 3'(i)) begin
            q <= cap_data;
         end
      end
      assign slots_flat[i*WIDTH +: WIDTH] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int j = 0; j < SLOTS; j++) begin
         if (rd_idx == 3'(j)) rd_data = slots_flat[j*WIDTH +: WIDTH];
      end
   end

endmodule

// File: rtl/sat_addr_gen.sv
module sat_addr_gen #(
   parameter int ADDR_W    = 12,
   parameter int ENT_W     = 8,
   parameter int BASE_ADDR = 0
) (
   input  logic [ENT_W-1:0]  ent,
   input  logic [2:0]        word,
   output logic [ADDR_W-1:0] addr
);

   localparam int OFS_W = ENT_W + 3;
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   logic [OFS_W-1:0] ofs;

   assign ofs  = {ent, word};
   assign addr = BASE + ADDR_W'(ofs);

endmodule

// File: rtl/sat_seq.sv
module sat_seq
   import sat_pkg::*;
#(
   parameter int N_ENTRIES = 256,
   parameter int ENT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vsync,
   output logic [ENT_W-1:0] ent,
   output logic [2:0]       word,
   output logic             cap_en,
   output logic             we,
   output logic             busy,
   output logic             done
);

   localparam logic [ENT_W-1:0] LAST_ENT  = ENT_W'(N_ENTRIES - 1);
   localparam logic [2:0]       LAST_SRC  = 3'(SRC_WORDS - 1);
   localparam logic [2:0]       LAST_WORD = 3'(WORDS_PER_ENTRY - 1);

   sat_state_e       state_q, state_d;
   logic [ENT_W-1:0] ent_q, ent_d;
   logic [2:0]       word_q, word_d;

   always_comb begin
      state_d = state_q;
      ent_d   = ent_q;
      word_d  = word_q;
      case (state_q)
         ST_IDLE: begin
            if (vsync) begin
               state_d = ST_RADDR;
               ent_d   = '0;
               word_d  = '0;
            end
         end
         ST_RADDR: state_d = ST_RCAP;
         ST_RCAP: begin
            if (word_q == LAST_SRC) begin
               state_d = ST_WRITE;
               word_d  = '0;
            end else begin
               state_d = ST_RADDR;
               word_d  = word_q + 3'd1;
            end
         end
         ST_WRITE: begin
            if (word_q == LAST_WORD) begin
               word_d = '0;
               if (ent_q == LAST_ENT) begin
                  state_d = ST_DONE;
               end else begin
                  state_d = ST_RADDR;
                  ent_d   = ent_q + 1'b1;
               end
            end else begin
               word_d = word_q + 3'd1;
            end
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ent_q   <= '0;
         word_q  <= '0;
      end else begin
         state_q <= state_d;
         ent_q   <= ent_d;
         word_q  <= word_d;
      end
   end

   assign ent    = ent_q;
   assign word   = word_q;
   assign cap_en = (state_q == ST_RCAP);
   assign we     = (state_q == ST_WRITE);
   assign busy   = (state_q == ST_RADDR) || (state_q == ST_RCAP) || (state_q == ST_WRITE);
   assign done   = (state_q == ST_DONE);

endmodule

// File: rtl/sat_xlate.sv
module sat_xlate
   import sat_pkg::*;
#(
   parameter int N_ENTRIES = 256,
   parameter int BASE_ADDR = 0,
   parameter int ADDR_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_i,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic [15:0]       ram_wdata_o,
   input  logic [15:0]       ram_rdata_i,
   output logic              ram_we_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int ENT_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

   if (N_ENTRIES < 1) begin : g_bad_count
      $error("sat_xlate: N_ENTRIES must be at least 1");
   end
   if (ADDR_W < ENT_W + 3) begin : g_bad_width
      $error("sat_xlate: ADDR_W too narrow for the table");
   end
   if (BASE_ADDR < 0 || (BASE_ADDR + WORDS_PER_ENTRY * N_ENTRIES) > (1 << ADDR_W)) begin : g_bad_base
      $error("sat_xlate: table does not fit the address space");
   end

   logic [ENT_W-1:0]  ent;
   logic [2:0]        word;
   logic              cap_en;
   logic              we;
   logic [DATA_W-1:0] buf_word;
   wr_sel_t           sel;

   sat_seq #(
      .N_ENTRIES(N_ENTRIES),
      .ENT_W    (ENT_W)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .vsync (vsync_i),
      .ent   (ent),
      .word  (word),
      .cap_en(cap_en),
      .we    (we),
      .busy  (busy_o),
      .done  (done_o)
   );

   sat_addr_gen #(
      .ADDR_W   (ADDR_W),
      .ENT_W    (ENT_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_addr (
      .ent (ent),
      .word(word),
      .addr(ram_addr_o)
   );

   assign sel = target_sel(word);

   sat_entry_buf #(
      .WIDTH(DATA_W),
      .SLOTS(SRC_WORDS)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .cap_idx (word),
      .cap_data(ram_rdata_i),
      .rd_idx  (sel.src),
      .rd_data (buf_word)
   );

   always_comb begin
      case (sel.kind)
         WK_SCALE: ram_wdata_o = UNITY_SCALE;
         WK_PAD:   ram_wdata_o = PAD_WORD;
         default:  ram_wdata_o = buf_word;
      endcase
   end

   assign ram_we_o = we;

endmodule

// File: rtl/sat_xlate_chk.sv
module sat_xlate_chk #(
   parameter int N_ENTRIES = 256,
   parameter int BASE_ADDR = 0,
   parameter int ADDR_W    = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vsync_i,
   input logic [ADDR_W-1:0] ram_addr_o,
   input logic [15:0]       ram_wdata_o,
   input logic              ram_we_o,
   input logic              busy_o,
   input logic              done_o
);

   localparam int PASS_CYC = 18 * N_ENTRIES;
   localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_ADDR);
   localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_ADDR + 8 * N_ENTRIES);

   int unsigned busy_cnt;
   logic [ADDR_W-1:0] rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= 0;
      else if (busy_o) busy_cnt <= busy_cnt + 1;
      else             busy_cnt <= 0;
   end

   assign rel = ram_addr_o - ADDR_W'(BASE_ADDR);

   // R8
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(ram_we_o) && !busy_o));

   // R8
   done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_cnt == PASS_CYC));

   // R4
   start_on_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(vsync_i));

   // R7
   busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (busy_o || done_o));

   // R5
   addr_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> ({1'b0, ram_addr_o} >= LO && {1'b0, ram_addr_o} < HI));

   // R2
   scale_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we_o && (rel[2:0] == 3'd4 || rel[2:0] == 3'd5)) |-> (ram_wdata_o == 16'h0101));

   // R3
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we_o && rel[2:0] == 3'd7) |-> (ram_wdata_o == 16'h0000));

   // R9
   we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> busy_o);

endmodule

bind sat_xlate sat_xlate_chk #(
   .N_ENTRIES(N_ENTRIES),
   .BASE_ADDR(BASE_ADDR),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vsync_i    (vsync_i),
   .ram_addr_o (ram_addr_o),
   .ram_wdata_o(ram_wdata_o),
   .ram_we_o   (ram_we_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/tb_sat_xlate.sv
module tb_sat_xlate;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 256;
   localparam int BASE       = 16;
   localparam int AW         = 12;
   localparam int MEM_WORDS  = 1 << AW;
   localparam int PASS       = 18 * N + 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          vsync;
   logic [AW-1:0] ram_addr;
   logic [15:0]   ram_wdata;
   logic [15:0]   ram_rdata;
   logic          ram_we;
   logic          busy;
   logic          done;

   logic [15:0] mem  [MEM_WORDS];
   logic [15:0] gold [MEM_WORDS];

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sat_xlate #(
      .N_ENTRIES(N),
      .BASE_ADDR(BASE),
      .ADDR_W   (AW)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .vsync_i    (vsync),
      .ram_addr_o (ram_addr),
      .ram_wdata_o(ram_wdata),
      .ram_rdata_i(ram_rdata),
      .ram_we_o   (ram_we),
      .busy_o     (busy),
      .done_o     (done)
   );

   always @(posedge clk) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input int e, input int w);
      int b = BASE + e * 8;
      case (w)
         0: return gold[b + 2];
         1: return gold[b + 3];
         2: return gold[b + 0];
         3: return gold[b + 1];
         4: return 16'h0101;
         5: return 16'h0101;
         6: return gold[b + 4];
         default: return 16'h0000;
      endcase
   endfunction

   task automatic fill(input int mode);
      for (int i = 0; i < MEM_WORDS; i++) begin
         logic [15:0] v;
         case (mode)
            0:       v = 16'($urandom);
            1:       v = 16'(i * 16'h0123 + 16'h0F0F);
            default: v = ((i % 3) == 0) ? 16'hFFFF : 16'h0000;
         endcase
         mem[i]  = v;
         gold[i] = v;
      end
   endtask

   task automatic run_pass(input bit stray);
      int c;
      @(negedge clk);
      vsync = 1'b1;
      @(negedge clk);
      vsync = 1'b0;
      chk(busy == 1'b1, "R4 busy after trigger", 32'(busy), 32'd1);
      c = 1;
      while (!done && c <= PASS + 20) begin
         @(negedge clk);
         c++;
         vsync = stray && (c == 100);
      end
      vsync = 1'b0;
      chk(c == PASS, stray ? "R7 done timing with stray trigger" : "R8 done timing",
          32'(c), 32'(PASS));
      @(negedge clk);
      chk(!done && !busy, "R8 done one cycle, busy low", {30'd0, done, busy}, 32'd0);
      repeat (30) @(negedge clk);
      chk(!busy && !done, stray ? "R7 no restart after stray trigger" : "R8 stays idle",
          {30'd0, done, busy}, 32'd0);
   endtask

   task automatic verify(input string tag);
      int bad1 = 0, bad2 = 0, bad3 = 0, bad5 = 0, bad6 = 0;
      logic [15:0] a1 = 0, e1 = 0, a2 = 0, e2 = 0, a3 = 0, e3 = 0, a5 = 0, e5 = 0, a6 = 0, e6 = 0;
      for (int e = 0; e < N; e++) begin
         for (int w = 0; w < 8; w++) begin
            logic [15:0] act = mem[BASE + e * 8 + w];
            logic [15:0] ex  = exp_word(e, w);
            if (act != ex) begin
               if (w == 4 || w == 5)      begin if (bad2 == 0) begin a2 = act; e2 = ex; end bad2++; end
               else if (w == 7)           begin if (bad3 == 0) begin a3 = act; e3 = ex; end bad3++; end
               else if (w == 0 || w == 2) begin if (bad6 == 0) begin a6 = act; e6 = ex; end bad6++; end
               else                       begin if (bad1 == 0) begin a1 = act; e1 = ex; end bad1++; end
            end
         end
      end
      for (int i = 0; i < MEM_WORDS; i++) begin
         if ((i < BASE || i >= BASE + 8 * N) && mem[i] != gold[i]) begin
            if (bad5 == 0) begin a5 = mem[i]; e5 = gold[i]; end
            bad5++;
         end
      end
      chk(bad1 == 0, {"R1 size/Y/attribute placement ", tag}, 32'(a1), 32'(e1));
      chk(bad2 == 0, {"R2 unity scale ", tag}, 32'(a2), 32'(e2));
      chk(bad3 == 0, {"R3 zero pad ", tag}, 32'(a3), 32'(e3));
      chk(bad6 == 0, {"R6 in-place X/code swap ", tag}, 32'(a6), 32'(e6));
      chk(bad5 == 0, {"R5 outside table untouched ", tag}, 32'(a5), 32'(e5));
   endtask

   task automatic snapshot();
      for (int i = 0; i < MEM_WORDS; i++) gold[i] = mem[i];
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'h5EED_0042);
      rst_n = 1'b0;
      vsync = 1'b0;
      fill(0);
      repeat (3) @(negedge clk);
      chk(!busy && !done && !ram_we, "R9 reset state", {29'd0, busy, done, ram_we}, 32'd0);
      // vsync during reset must not start a pass
      vsync = 1'b1;
      @(negedge clk);
      vsync = 1'b0;
      chk(!busy && !ram_we, "R9 no activity in reset", {30'd0, busy, ram_we}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !done, "R4 idle without trigger", {30'd0, busy, done}, 32'd0);

      // random table
      run_pass(1'b0);
      verify("random");

      // second frame on the already converted table
      snapshot();
      run_pass(1'b0);
      verify("back-to-back");

      // stray trigger in mid-pass
      fill(0);
      run_pass(1'b1);
      verify("stray trigger");

      // directed positional pattern
      fill(1);
      run_pass(1'b0);
      verify("positional");

      // directed all-ones / zero pattern
      fill(2);
      run_pass(1'b0);
      verify("ones-zeros");

      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      finish_run();
   end

endmodule